// File: doc/BRIEF.md
# Serial Character Transmitter with Host-Supplied Extra Bit

This block turns one byte at a time into an asynchronous serial frame on a single output line. The host places a word in a one-entry holding buffer with a load strobe. Whenever the frame shifter is idle, the word moves from the buffer into the shifter, and the buffer is free again for the next word. Each frame starts with a low start bit. The data bits follow, least significant first. An optional extra bit comes next, and one or two high stop bits close the frame.

The extra bit is taken exactly as the host supplies it; the block does not compute parity. This lets the slot carry an address/data marker for 9-bit multidrop networks, or a parity value that software calculates. Three settings are captured with each word when it is loaded: 7-bit or 8-bit characters, whether the extra bit is sent, and one or two stop bits. A baud tick at sixteen times the bit rate paces the output. A separate quiet flag tells the host when both the buffer and the shifter are empty, so a line driver may be switched off.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is 1, the buffer-empty flag is 1 and the quiet flag is 1.
- R2: A frame is sent as: one start bit of value 0, then the data bits least significant first, then the extra bit if enabled, then the stop bits of value 1. The line rests at 1 between frames.
- R3: Every bit lasts exactly 16 baud ticks. Ticks are counted only while a frame is in progress. A tick in the same clock cycle in which a word enters the shifter is not counted, so a frame of N bits occupies exactly 16*N ticks.
- R4: With short_word_i=1 only data bits 0..6 are sent and bit 7 has no effect on the line. With short_word_i=0 bits 0..7 are sent.
- R5: With xbit_en_i=1, xbit_i is sent unchanged right after the last data bit. With xbit_en_i=0 no extra bit is sent and xbit_i has no effect.
- R6: two_stop_i=0 sends one stop bit and two_stop_i=1 sends two.
- R7: An accepted load clears the buffer-empty flag on the next clock edge. The flag returns to 1 on the edge on which the word moves into the shifter, and that same edge drives the start bit onto the line.
- R8: A word may be loaded while a frame is being shifted out. It is sent directly after the current frame's last stop bit.
- R9: A load strobe while the buffer-empty flag is 0 is ignored: no word is taken and no extra frame appears.
- R10: The format settings are captured with the word on the load edge. Later changes on those inputs do not alter that word's frame.
- R11: The quiet flag is 1 only when the shifter is idle and the buffer is empty. It rises on the edge that ends the last stop bit of the last queued word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Baud tick, one clock wide, 16 per bit time |
| load_i | input | 1 | Load strobe for the holding buffer |
| data_i | input | DATA_W | Character to send |
| xbit_i | input | 1 | Host-supplied extra bit |
| xbit_en_i | input | 1 | 1: send the extra bit |
| short_word_i | input | 1 | 1: send DATA_W-1 data bits |
| two_stop_i | input | 1 | 1: send two stop bits |
| tx_o | output | 1 | Serial line, idle high |
| buf_empty_o | output | 1 | Holding buffer can accept a word |
| quiet_o | output | 1 | Buffer and shifter both empty |

## Verification
Two events can land on the same clock edge: a baud tick, and the move of a buffered word into the shifter. If the tick were counted there, the start bit would be one tick short. The bench provokes this by timing a load so that the move falls exactly on a tick. It then counts the ticks from the first low line sample up to the rise of the quiet flag and expects exactly sixteen per bit. A second coincidence is a load strobe that arrives while the buffer is still full behind a busy shifter. That load is judged ignored when only the two queued frames appear and the quiet flag rises on schedule after the second one.

// File: rtl/uftx_pkg.sv
// Package: shared frame-format type for the serial character transmitter.
package uftx_pkg;

    // Per-word format settings, captured together with the character.
    typedef struct packed {
        logic xbit_en;     // send the host-supplied extra bit
        logic short_word;  // drop the most significant data bit
        logic two_stop;    // two stop bits instead of one
    } uftx_cfg_t;

endpackage

// File: rtl/uftx_holdbuf.sv
// Module: uftx_holdbuf
// One-entry holding register in front of the frame shifter.
// Assumes take_i is raised only while full_o is 1. A load while full is dropped.
module uftx_holdbuf
    import uftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              xbit_i,
    input  uftx_cfg_t         cfg_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o,
    output logic              xbit_o,
    output uftx_cfg_t         cfg_o
);

    // Occupancy flag: set by an accepted load, cleared when the shifter takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
        end else if (take_i) begin
            full_o <= 1'b0;
        end else if (load_i && !full_o) begin
            full_o <= 1'b1;
        end
    end

    // Payload capture: character, extra bit and format settings on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            xbit_o <= 1'b0;
            cfg_o  <= '0;
        end else if (load_i && !full_o) begin
            data_o <= data_i;
            xbit_o <= xbit_i;
            cfg_o  <= cfg_i;
        end
    end

endmodule

// File: rtl/uftx_shifter.sv
// Module: uftx_shifter
// Assembles a frame from a word and its settings and shifts it out LSB first.
// Each bit lasts OVERSAMPLE ticks. Assumes start_i is raised only while busy_o is 0.
// A tick on the start edge is not counted.
module uftx_shifter
    import uftx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              xbit_i,
    input  uftx_cfg_t         cfg_i,
    output logic              busy_o,
    output logic              tx_o
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int BITS_W  = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);

    logic [FRAME_W-1:0] frame;
    logic [BITS_W-1:0]  n_data;
    logic [BITS_W-1:0]  n_bits;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   tick_cnt;
    logic [BITS_W-1:0]  bits_left;

    // Frame image: start bit, data LSB first, optional extra bit, ones above.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        n_data   = cfg_i.short_word ? BITS_W'(DATA_W - 1) : BITS_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (BITS_W'(i) < n_data) begin
                frame[i+1] = data_i[i];
            end
        end
        if (cfg_i.xbit_en) begin
            if (cfg_i.short_word) begin
                frame[DATA_W] = xbit_i;
            end else begin
                frame[DATA_W+1] = xbit_i;
            end
        end
        n_bits = BITS_W'(1) + n_data + BITS_W'(cfg_i.xbit_en)
               + (cfg_i.two_stop ? BITS_W'(2) : BITS_W'(1));
    end

    // Shift engine: load on start, advance one bit every OVERSAMPLE ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            shreg     <= '1;
            tick_cnt  <= '0;
            bits_left <= '0;
        end else if (start_i) begin
            busy_o    <= 1'b1;
            shreg     <= frame;
            tick_cnt  <= '0;
            bits_left <= n_bits;
        end else if (busy_o && tick_i) begin
            if (tick_cnt == LAST_TICK) begin
                tick_cnt  <= '0;
                shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                bits_left <= bits_left - BITS_W'(1);
                if (bits_left == BITS_W'(1)) begin
                    busy_o <= 1'b0;
                end
            end else begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
        end
    end

    // Line driver: current frame bit while busy, idle high otherwise.
    always_comb tx_o = busy_o ? shreg[0] : 1'b1;

endmodule

// File: rtl/uart_frame_tx.sv
// Module: uart_frame_tx
// Serial character transmitter: a holding buffer feeding a frame shifter.
// Assumes tick_i is one clock wide at OVERSAMPLE times the bit rate.
// The extra bit is sent as supplied; no parity is computed here.
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              xbit_i,
    input  logic              xbit_en_i,
    input  logic              short_word_i,
    input  logic              two_stop_i,
    output logic              tx_o,
    output logic              buf_empty_o,
    output logic              quiet_o
);

    uftx_cfg_t         cfg_in;
    uftx_cfg_t         cfg_held;
    logic [DATA_W-1:0] data_held;
    logic              xbit_held;
    logic              buf_full;
    logic              shift_busy;
    logic              take;

    // Pack the format inputs into the shared settings type.
    always_comb begin
        cfg_in.xbit_en    = xbit_en_i;
        cfg_in.short_word = short_word_i;
        cfg_in.two_stop   = two_stop_i;
    end

    // Hand-off: move the buffered word whenever the shifter is idle.
    always_comb take = buf_full && !shift_busy;

    uftx_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .data_i (data_i),
        .xbit_i (xbit_i),
        .cfg_i  (cfg_in),
        .take_i (take),
        .full_o (buf_full),
        .data_o (data_held),
        .xbit_o (xbit_held),
        .cfg_o  (cfg_held)
    );

    uftx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .start_i (take),
        .data_i  (data_held),
        .xbit_i  (xbit_held),
        .cfg_i   (cfg_held),
        .busy_o  (shift_busy),
        .tx_o    (tx_o)
    );

    // Status outputs for the host.
    always_comb begin
        buf_empty_o = !buf_full;
        quiet_o     = !buf_full && !shift_busy;
    end

endmodule

// File: rtl/uftx_checker.sv
// Module: uftx_checker
// Temporal properties on the transmitter's ports, bound to every instance.
module uftx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic load_i,
    input logic tx_o,
    input logic buf_empty_o,
    input logic quiet_o
);

    // R7: an accepted load fills the buffer on the next edge
    a_r7_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && buf_empty_o) |=> !buf_empty_o);

    // R7: the buffer frees exactly when a frame begins with its start bit
    a_r7_free_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty_o) |-> !tx_o);

    // R11: quiet implies an empty buffer and an idle-high line
    a_r11_quiet_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_o |-> (buf_empty_o && tx_o));

    // R3: a rising line edge only ever follows a consumed baud tick
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_o) |-> $past(tick_i));

    // R11: quiet can rise only from a busy shifter ending on a tick
    a_r11_quiet_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiet_o) |-> $past(tick_i));

endmodule

bind uart_frame_tx uftx_checker u_uftx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .load_i      (load_i),
    .tx_o        (tx_o),
    .buf_empty_o (buf_empty_o),
    .quiet_o     (quiet_o)
);

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
// Directed bench for uart_frame_tx; one task per scenario.
module uart_frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       xbit_i = 1'b0;
    logic       xbit_en_i = 1'b0;
    logic       short_word_i = 1'b0;
    logic       two_stop_i = 1'b0;
    logic       tx_o;
    logic       buf_empty_o;
    logic       quiet_o;

    int n_checks = 0;
    int n_fails  = 0;
    int tdiv     = 0;

    uart_frame_tx u_uart_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .load_i       (load_i),
        .data_i       (data_i),
        .xbit_i       (xbit_i),
        .xbit_en_i    (xbit_en_i),
        .short_word_i (short_word_i),
        .two_stop_i   (two_stop_i),
        .tx_o         (tx_o),
        .buf_empty_o  (buf_empty_o),
        .quiet_o      (quiet_o)
    );

    always #2 clk = ~clk;

    // Baud tick every third clock, changed on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            tdiv   = (tdiv == 2) ? 0 : tdiv + 1;
            tick_i <= (tdiv == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected frame from the requirements: start, data LSB first, extra, stops.
    function automatic void mk_frame(input logic [7:0] d, input bit x, input bit en,
                                     input bit sh, input bit two,
                                     output logic [11:0] f, output int nb);
        int nd;
        nd   = sh ? 7 : 8;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) f[1+i] = d[i];
        if (en) f[1+nd] = x;
        nb = 1 + nd + (en ? 1 : 0) + (two ? 2 : 1);
    endfunction

    task automatic load_word(input logic [7:0] d, input bit x, input bit en,
                             input bit sh, input bit two);
        @(negedge clk);
        data_i = d; xbit_i = x; xbit_en_i = en; short_word_i = sh; two_stop_i = two;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Tick-accurate receiver: samples each bit at its 8th tick, optionally checks end time.
    task automatic rx_frame(input logic [11:0] f, input int nb, input bit end_chk,
                            input string tag);
        int n = 0;
        int g = 0;
        while (tx_o !== 1'b0 && g < 4000) begin @(posedge clk); #1; g++; end
        chk(tx_o === 1'b0, {tag, " start"}, tx_o, 0);
        for (int b = 0; b < nb; b++) begin
            g = 0;
            while (n < 8 + 16*b && g < 4000) begin
                @(posedge clk); #1; g++;
                if (tick_i) n++;
            end
            chk(tx_o === f[b], $sformatf("%s bit%0d", tag, b), tx_o, f[b]);
        end
        if (end_chk) begin
            g = 0;
            while (quiet_o !== 1'b1 && g < 4000) begin
                @(posedge clk); #1; g++;
                if (tick_i) n++;
            end
            chk(n == 16*nb, {tag, " R3 R11 ticks to quiet"}, n, 16*nb);
        end
    endtask

    task automatic send_and_check(input logic [7:0] d, input bit x, input bit en,
                                  input bit sh, input bit two, input string tag);
        logic [11:0] f;
        int nb;
        mk_frame(d, x, en, sh, two, f, nb);
        load_word(d, x, en, sh, two);
        rx_frame(f, nb, 1'b1, tag);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk(tx_o === 1'b1, "R1 line idle", tx_o, 1);
        chk(buf_empty_o === 1'b1, "R1 empty flag", buf_empty_o, 1);
        chk(quiet_o === 1'b1, "R1 quiet flag", quiet_o, 1);
    endtask

    // R7: empty flag timing around the load and the hand-off.
    task automatic t_flag();
        logic [11:0] f;
        int nb;
        mk_frame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, f, nb);
        @(negedge clk);
        data_i = 8'hA5; xbit_en_i = 0; short_word_i = 0; two_stop_i = 0; load_i = 1'b1;
        @(posedge clk); #1;
        load_i = 1'b0;
        chk(buf_empty_o === 1'b0, "R7 cleared after load", buf_empty_o, 0);
        chk(quiet_o === 1'b0, "R11 not quiet with full buffer", quiet_o, 0);
        @(posedge clk); #1;
        chk(buf_empty_o === 1'b1, "R7 set on hand-off", buf_empty_o, 1);
        chk(tx_o === 1'b0, "R7 start bit on hand-off", tx_o, 0);
        rx_frame(f, nb, 1'b1, "R2 R6 8N1");
    endtask

    // R4 R5: short word with bit 7 set, extra bit 0 in the slot bit 7 would take.
    task automatic t_short();
        send_and_check(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0, "R4 R5 short word");
    endtask

    // R5 R6: 8 bits, extra bit 1, two stops.
    task automatic t_extra_two();
        send_and_check(8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, "R5 R6 extra and two stops");
    endtask

    // R5: extra disabled with xbit 0 must not appear; slot is a stop bit.
    task automatic t_no_extra();
        send_and_check(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R5 extra ignored");
    endtask

    // R8 R9: second word queued while busy, third dropped.
    task automatic t_queue();
        logic [11:0] fa, fb;
        int na, nb2;
        mk_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, fa, na);
        mk_frame(8'h0F, 1'b1, 1'b1, 1'b1, 1'b0, fb, nb2);
        load_word(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        load_word(8'h0F, 1'b1, 1'b1, 1'b1, 1'b0);
        #1;
        chk(buf_empty_o === 1'b0, "R8 queued while busy", buf_empty_o, 0);
        chk(quiet_o === 1'b0, "R11 busy not quiet", quiet_o, 0);
        load_word(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
        rx_frame(fa, na, 1'b0, "R8 first");
        rx_frame(fb, nb2, 1'b1, "R8 R9 second, third dropped");
    endtask

    // R10: settings changed after the load do not alter the frame.
    task automatic t_capture();
        logic [11:0] f;
        int nb;
        mk_frame(8'h80, 1'b1, 1'b1, 1'b1, 1'b0, f, nb);
        load_word(8'h80, 1'b1, 1'b1, 1'b1, 1'b0);
        xbit_i = 1'b0; xbit_en_i = 1'b0; short_word_i = 1'b0; two_stop_i = 1'b1;
        rx_frame(f, nb, 1'b1, "R10 captured settings");
    endtask

    // R3: hand-off edge coincides with a tick; that tick must not count.
    task automatic t_tick_on_handoff();
        logic [11:0] f;
        int nb;
        int g = 0;
        mk_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, f, nb);
        @(negedge clk); #1;
        while (tick_i !== 1'b1 && g < 10) begin @(negedge clk); #1; g++; end
        @(negedge clk); #1;
        @(negedge clk); #1;
        data_i = 8'h96; xbit_i = 0; xbit_en_i = 0; short_word_i = 0; two_stop_i = 0;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        rx_frame(f, nb, 1'b1, "R3 tick on hand-off");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_flag();
        t_short();
        t_extra_two();
        t_no_extra();
        t_queue();
        t_capture();
        t_tick_on_handoff();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule